// File: doc/BRIEF.md
# Bus Master Latency-Timer Burst Controller

This block sequences bursts on the initiator side of one port of a bus bridge. It accepts one queued request at a time from a posted-write buffer or a prefetching read engine. Each request carries a kind, a DWORD-aligned start address and a word count. The block waits for the bus grant, then raises its FRAME request and counts down a master latency timer. It advances the DWORD address on every completed data phase. While the timer has run out and the grant is absent, it cuts the burst short.

What happens after a cut depends on the request kind. A posted write is reissued as soon as the grant returns. The new burst starts at the first DWORD that was not delivered and carries only the remaining words. A prefetching read that is cut is abandoned, and the block reports that it stopped. A Memory Write and Invalidate burst is never cut by the timer; it runs until its last word.

Top module: `lt_burst_ctrl`

## Requirements
- R1: On the clock edge at which a burst starts, the latency timer loads `lat_value`. It then falls by one per burst cycle down to zero. It is expired in the burst cycle where it reads zero, so with value L it is expired from burst cycle L onward (cycle 0 is the first cycle `frame_req` is high).
- R2: A burst that is not on its last word continues while the timer is not expired or `gnt` is high. It is cut only in a cycle where both the timer is expired and `gnt` is low.
- R3: A burst of kind 2'b10 (Memory Write and Invalidate) is never cut by the timer. It ends only after its last word.
- R4: A data phase completes only in a burst cycle where `irdy` and `trdy` are both high. Each completed phase adds 4 to `cur_addr` and subtracts 1 from `words_left`.
- R5: A cut burst of kind 2'b00 (posted write) gives a one-cycle `resume_pulse`. It then raises `frame_req` again once `gnt` is seen.
- R6: The reissued write burst starts at the address of the first undelivered DWORD, shown on `burst_addr`. `words_left` equals the original count minus the words already delivered.
- R7: A cut burst of kind 2'b01 or 2'b11 (prefetching read) gives a one-cycle `stop_pulse` and returns to idle. No further FRAME is raised for that request.
- R8: When the last word's data phase completes, the block gives a one-cycle `done_pulse` and returns to idle. This holds even if a cut would have applied in the same cycle.
- R9: After reset, `busy`, `frame_req` and all three pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | New request present; taken only while idle |
| req_kind | input | 2 | 00 posted write, 01 prefetch read, 10 Memory Write and Invalidate, 11 read |
| req_addr | input | 32 | DWORD-aligned start byte address |
| req_words | input | 8 | Number of DWORDs, at least 1 |
| lat_value | input | 8 | Programmed latency timer value |
| gnt | input | 1 | Bus grant |
| irdy | input | 1 | Initiator ready for the current data phase |
| trdy | input | 1 | Target ready for the current data phase |
| busy | output | 1 | A request is in progress |
| frame_req | output | 1 | FRAME request, high for each burst cycle |
| burst_addr | output | 32 | Start address of the current or latest burst |
| cur_addr | output | 32 | Address of the next DWORD to deliver |
| words_left | output | 8 | DWORDs not yet delivered |
| resume_pulse | output | 1 | Write cut by the timer, to be reissued |
| stop_pulse | output | 1 | Read cut by the timer, abandoned |
| done_pulse | output | 1 | All words delivered |

## Verification
The assertions assume that a request carries a non-zero word count. They also assume that `req_kind`, `req_addr`, `req_words` and `lat_value` stay steady between acceptance and the end of the request, because the timer reloads `lat_value` at every restart. The bench sets these inputs only while the block is idle and holds them until `busy` falls. It keeps `irdy` high and changes `gnt` and `trdy` only at falling edges. During the first burst it withdraws the grant at a chosen cycle, and it always grants again after a cut.

// File: rtl/lt_burst_pkg.sv
package lt_burst_pkg;

  // Request kinds: encodings are part of the port contract
  typedef enum logic [1:0] {
    K_PWRITE = 2'b00,
    K_PREAD  = 2'b01,
    K_MWI    = 2'b10,
    K_PREAD2 = 2'b11
  } burst_kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_ARB   = 2'b01,
    S_BURST = 2'b10
  } seq_state_e;

  localparam int DWORD_BYTES = 4;

  // Kinds whose cut bursts are reissued
  function automatic logic kind_resumes(input burst_kind_e k);
    return (k == K_PWRITE);
  endfunction

  // Kinds that the latency timer may not cut
  function automatic logic kind_timer_exempt(input burst_kind_e k);
    return (k == K_MWI);
  endfunction

endpackage

// File: rtl/lt_latency_timer.sv
module lt_latency_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             expired_o,
  output logic [LAT_W-1:0] count_o
);

  localparam logic [LAT_W-1:0] ZERO = '0;

  logic [LAT_W-1:0] cnt_q;

  // Saturating step toward zero
  function automatic logic [LAT_W-1:0] tick_down(input logic [LAT_W-1:0] v);
    return (v == ZERO) ? ZERO : v - 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= ZERO;
    else if (load_i)  cnt_q <= lat_i;
    else if (run_i)   cnt_q <= tick_down(cnt_q);
  end

  assign expired_o = run_i && (cnt_q == ZERO);
  assign count_o   = cnt_q;

  // R1: the programmed value is taken at burst start
  p_load_value_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(lat_i)));

  // R1: one step down per burst cycle while above zero
  p_countdown_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lt_addr_tracker.sv
module lt_addr_tracker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  words_i,
  input  logic              mark_i,
  input  logic              xfer_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] burst_addr_o,
  output logic [CNT_W-1:0]  words_left_o,
  output logic              last_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(lt_burst_pkg::DWORD_BYTES);
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] cur_q, start_q;
  logic [CNT_W-1:0]  left_q;

  function automatic logic [ADDR_W-1:0] next_dword(input logic [ADDR_W-1:0] a);
    return a + STEP;
  endfunction

  function automatic logic [CNT_W-1:0] one_fewer(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - ONE;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      start_q <= '0;
      left_q  <= '0;
    end else if (capture_i) begin
      cur_q   <= addr_i;
      start_q <= addr_i;
      left_q  <= words_i;
    end else begin
      if (mark_i) start_q <= cur_q;
      if (xfer_i) begin
        cur_q  <= next_dword(cur_q);
        left_q <= one_fewer(left_q);
      end
    end
  end

  assign cur_addr_o   = cur_q;
  assign burst_addr_o = start_q;
  assign words_left_o = left_q;
  assign last_o       = (left_q == ONE);

  // R4: one DWORD of progress per completed data phase
  p_dword_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !capture_i) |=> (cur_q == $past(cur_q) + STEP) && (left_q == $past(left_q) - ONE));

  // R4: no phase completes with nothing left to send
  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |-> (left_q != '0));

  // R6: a (re)started burst begins at the first undelivered DWORD
  p_restart_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_i && !capture_i && !xfer_i) |=> (start_q == $past(cur_q)) && (left_q == $past(left_q)));

endmodule

// File: rtl/lt_seq_fsm.sv
module lt_seq_fsm
  import lt_burst_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [1:0]  req_kind_i,
  input  logic        gnt_i,
  input  logic        xfer_i,
  input  logic        last_i,
  input  logic        expired_i,
  output logic        capture_o,
  output logic        start_o,
  output logic        burst_o,
  output logic        busy_o,
  output logic        resume_o,
  output logic        stop_o,
  output logic        done_o
);

  seq_state_e  st_q, st_d;
  burst_kind_e kind_q;
  logic        resume_q, stop_q, done_q;

  // Named internal events
  logic fin_w;   // last word delivered this cycle
  logic cut_w;   // timer termination this cycle

  assign burst_o   = (st_q == S_BURST);
  assign capture_o = (st_q == S_IDLE) && req_valid_i;
  assign start_o   = (st_q == S_ARB) && gnt_i;
  assign fin_w     = burst_o && xfer_i && last_i;
  assign cut_w     = burst_o && expired_i && !gnt_i && !kind_timer_exempt(kind_q) && !fin_w;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (req_valid_i) st_d = S_ARB;
      S_ARB:   if (gnt_i)       st_d = S_BURST;
      S_BURST: begin
        if (fin_w)                            st_d = S_IDLE;
        else if (cut_w && kind_resumes(kind_q)) st_d = S_ARB;
        else if (cut_w)                       st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      kind_q   <= K_PWRITE;
      resume_q <= 1'b0;
      stop_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      if (capture_o) kind_q <= burst_kind_e'(req_kind_i);
      resume_q <= cut_w && kind_resumes(kind_q);
      stop_q   <= cut_w && !kind_resumes(kind_q);
      done_q   <= fin_w;
    end
  end

  assign busy_o   = (st_q != S_IDLE);
  assign resume_o = resume_q;
  assign stop_o   = stop_q;
  assign done_o   = done_q;

  // R2: no cut while the timer runs or the grant is held
  p_hold_until_expiry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_o && !(xfer_i && last_i) && (!expired_i || gnt_i)) |=> (st_q == S_BURST));

  // R3: Memory Write and Invalidate keeps going regardless of the timer
  p_mwi_exempt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_o && kind_q == K_MWI && !(xfer_i && last_i)) |=> (st_q == S_BURST));

  // R5: a resumed write waits for the grant again
  p_write_resumes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_q |-> (st_q == S_ARB));

  // R7: a cut read goes idle
  p_read_stops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q |-> (st_q == S_IDLE));

  // R8: completion returns to idle
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (st_q == S_IDLE));

  // R8: at most one outcome per cycle
  p_one_outcome_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({resume_q, stop_q, done_q}));

endmodule

// File: rtl/lt_burst_ctrl.sv
module lt_burst_ctrl
  import lt_burst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int LAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_words,
  input  logic [LAT_W-1:0]  lat_value,
  input  logic              gnt,
  input  logic              irdy,
  input  logic              trdy,
  output logic              busy,
  output logic              frame_req,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  words_left,
  output logic              resume_pulse,
  output logic              stop_pulse,
  output logic              done_pulse
);

  logic capture_w, start_w, burst_w, xfer_w, last_w, expired_w;
  logic [LAT_W-1:0] timer_cnt_w;

  // Data phase completes only with both sides ready inside a burst
  assign xfer_w    = burst_w && irdy && trdy;
  assign frame_req = burst_w;

  lt_latency_timer #(.LAT_W(LAT_W)) u_timer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .load_i    (start_w),
    .run_i     (burst_w),
    .lat_i     (lat_value),
    .expired_o (expired_w),
    .count_o   (timer_cnt_w)
  );

  lt_addr_tracker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .capture_i    (capture_w),
    .addr_i       (req_addr),
    .words_i      (req_words),
    .mark_i       (start_w),
    .xfer_i       (xfer_w),
    .cur_addr_o   (cur_addr),
    .burst_addr_o (burst_addr),
    .words_left_o (words_left),
    .last_o       (last_w)
  );

  lt_seq_fsm u_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_kind_i  (req_kind),
    .gnt_i       (gnt),
    .xfer_i      (xfer_w),
    .last_i      (last_w),
    .expired_i   (expired_w),
    .capture_o   (capture_w),
    .start_o     (start_w),
    .burst_o     (burst_w),
    .busy_o      (busy),
    .resume_o    (resume_pulse),
    .stop_o      (stop_pulse),
    .done_o      (done_pulse)
  );

  // R1: expiry is never reported while the timer still holds a count
  p_expiry_at_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    expired_w |-> (timer_cnt_w == '0));

  // R5: FRAME only rises after a grant was seen
  p_frame_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_req) |-> $past(gnt));

endmodule

// File: tb/lt_burst_ctrl_bench.sv
module lt_burst_ctrl_bench;

  localparam int EV_FRAME = 0, EV_RESUME = 1, EV_STOP = 2, EV_DONE = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_words = '0;
  logic [7:0]  lat_value = '0;
  logic        gnt = 1'b0, irdy = 1'b1, trdy = 1'b1;
  logic        busy, frame_req, resume_pulse, stop_pulse, done_pulse;
  logic [31:0] burst_addr, cur_addr;
  logic [7:0]  words_left;

  lt_burst_ctrl u_lt_burst_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_words(req_words), .lat_value(lat_value),
    .gnt(gnt), .irdy(irdy), .trdy(trdy), .busy(busy), .frame_req(frame_req),
    .burst_addr(burst_addr), .cur_addr(cur_addr), .words_left(words_left),
    .resume_pulse(resume_pulse), .stop_pulse(stop_pulse), .done_pulse(done_pulse)
  );

  typedef struct {
    int          ev;
    logic [31:0] addr;
    int          left;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  int cycles = 0;
  logic frame_prev = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int ev, input logic [31:0] a, input int left, input string tag);
    exp_t e;
    e.ev = ev; e.addr = a; e.left = left; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: pops an expected item for each observed event
  task automatic take(input int ev, input logic [31:0] a, input int left);
    exp_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R7", "unexpected event", 32'(ev), 32'hFFFF_FFFF);
    end else begin
      e = q.pop_front();
      chk(ev == e.ev, e.tag, "event kind", 32'(ev), 32'(e.ev));
      if (ev == e.ev)
        chk(a == e.addr && left == e.left, e.tag, "addr/left",
            {a[23:0], 8'(left)}, {e.addr[23:0], 8'(e.left)});
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_req && !frame_prev) take(EV_FRAME, burst_addr, int'(words_left));
      if (resume_pulse) take(EV_RESUME, cur_addr, int'(words_left));
      if (stop_pulse)   take(EV_STOP, cur_addr, int'(words_left));
      if (done_pulse)   take(EV_DONE, cur_addr, int'(words_left));
    end
    frame_prev = frame_req;
  end

  // Driver: pushes the expected outcome, then runs the request.
  // Grant is held for g burst cycles of the first burst; a cut falls in
  // cycle max(lat, g). With stall, trdy is high only in even burst cycles.
  task automatic run(input logic [1:0] kind, input logic [31:0] a, input int w,
                     input int lat, input int g, input bit stall, input string tag);
    int  t = (lat > g) ? lat : g;
    int  n = stall ? (t / 2 + 1) : (t + 1);
    int  k = 0;
    bit  ph = 1'b0;
    bit  exempt = (kind == 2'b10);
    push(EV_FRAME, a, w, tag);
    if (exempt || n >= w) begin
      push(EV_DONE, a + 32'(4 * w), 0, tag);
    end else if (kind == 2'b00) begin
      push(EV_RESUME, a + 32'(4 * n), w - n, tag);
      push(EV_FRAME,  a + 32'(4 * n), w - n, tag);
      push(EV_DONE,   a + 32'(4 * w), 0, tag);
    end else begin
      push(EV_STOP, a + 32'(4 * n), w - n, tag);
    end
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = a; req_words = 8'(w);
    lat_value = 8'(lat); gnt = 1'b0; irdy = 1'b1; trdy = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int guard = 0; guard < 1000; guard++) begin
      if (frame_req) begin
        if (!ph) begin
          gnt  = (k < g);
          trdy = stall ? (k % 2 == 0) : 1'b1;
          k++;
        end else begin
          gnt = 1'b1; trdy = 1'b1;
        end
      end else begin
        if (!busy) break;
        if (k > 0) ph = 1'b1;
        gnt = 1'b1; trdy = 1'b1;
      end
      @(negedge clk);
    end
    gnt = 1'b0; trdy = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !frame_req, "R9", "busy/frame after reset", {busy, frame_req}, 0);
    chk(!resume_pulse && !stop_pulse && !done_pulse, "R9", "pulses after reset",
        {resume_pulse, stop_pulse, done_pulse}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(2'b00, 32'h0000_1000, 8,  2, 4, 1'b0, "R2/R5/R6");  // cut at cycle 4, 5 sent
    run(2'b00, 32'h0000_2000, 10, 5, 0, 1'b0, "R1/R6");     // cut when timer hits zero
    run(2'b01, 32'h0000_3000, 8,  2, 1, 1'b0, "R7");        // read cut, 3 fetched
    // R7: no reissue of the cut read even with the grant held
    gnt = 1'b1;
    repeat (10) @(negedge clk);
    chk(!frame_req && !busy, "R7", "no FRAME after read stop", {frame_req, busy}, 0);
    gnt = 1'b0;
    run(2'b10, 32'h0000_4000, 6,  1, 0, 1'b0, "R3");        // MWI ignores expiry
    run(2'b00, 32'h0000_5000, 3,  6, 0, 1'b0, "R8");        // finishes before expiry
    run(2'b00, 32'h0000_6000, 8,  3, 0, 1'b1, "R4");        // stalled phases: 2 sent
    run(2'b00, 32'h0000_7000, 3,  2, 0, 1'b0, "R8");        // done beats cut same cycle
    run(2'b11, 32'h0000_8000, 4,  0, 0, 1'b0, "R7/R1");     // zero latency read
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R8", "events left unobserved", 32'(q.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule